// File: doc/BRIEF.md
# Time-Multiplexed Space Switch

This block joins a set of incoming time-division highways to a set of outgoing highways through a crosspoint matrix whose setting changes every time-slot. Every highway carries one 8-bit sample per clock cycle, and each cycle is one time-slot. A slot counter runs from 0 to 31 and returns to 0 at the end of the frame. A frame-sync pulse marks slot 0.

Every outgoing highway owns a column of control memory with one word per slot. In each slot the word indexed by the current slot number is read from every column. If the word is valid, it names the incoming highway whose sample is copied to that output in the same cycle, so a sample never changes its slot position. If the word is not valid, the output carries the idle byte 0xFF. Because the selection changes from slot to slot, each crosspoint serves a different connection in every slot of the frame.

A control processor loads and clears connections through a single write port that gives a column, a slot and a word.

Top module: `tsw_space_switch`

## Requirements
- R1: After reset every control word is invalid, so every output carries 0xFF in every slot until a connection is written.
- R2: In a slot whose word in output column o is valid with source field k, output o equals input k in the same cycle.
- R3: In a slot whose word in column o is invalid, output o carries the idle byte 0xFF.
- R4: Without frame sync, the slot number goes up by one each cycle and wraps from 31 to 0. The first cycle after reset is slot 0.
- R5: A cycle with `fsync_i` high is slot 0, and the next cycle is slot 1.
- R6: A write of column c, slot s takes effect from the next occurrence of slot s. If the write happens during slot s, that cycle still uses the previous word.
- R7: A write with `cw_valid_i` low erases the word, and the output idles in that slot from then on.
- R8: Columns are independent. Several outputs may select the same input in the same slot, and a write to one column leaves the others unchanged.
- R9: One column can select different inputs in different slots of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time-slot |
| rst_n | input | 1 | Synchronous reset, active low |
| fsync_i | input | 1 | Frame sync; the current cycle is slot 0 |
| hw_in_i | input | N_IN*8 | Incoming samples; highway k occupies bits [8k+7:8k] |
| cw_en_i | input | 1 | Control write strobe |
| cw_col_i | input | COL_W | Output column to write |
| cw_slot_i | input | SLOT_W | Slot word to write |
| cw_valid_i | input | 1 | 1 loads a connection, 0 erases it |
| cw_src_i | input | SRC_W | Input highway number to connect |
| hw_out_o | output | N_OUT*8 | Outgoing samples; highway o occupies bits [8o+7:8o] |

## Verification
The bench targets the write that lands in the slot currently being switched. A design that used the new word at once would show the new source one frame early. It also places a frame sync in the middle of a frame and runs across the wrap from 31 to 0; a counter that ignored the sync or wrapped late would read the wrong word for the rest of the frame. Broadcast from one input to several columns, and erase followed by idle output, catch cross-column write decode errors and a valid bit that never clears. Random traffic with random writes and occasional syncs, compared against a bench model of the memory, covers the remaining slot and column combinations.

// File: rtl/tsw_pkg.sv
// Package tsw_pkg
// Shared constants for the time-multiplexed space switch.
// Assumes every highway sample is one byte wide.
package tsw_pkg;
    localparam int          SAMPLE_W  = 8;
    localparam logic [7:0]  IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/tsw_slot_ctr.sv
// Module tsw_slot_ctr
// Gives the time-slot number of the current cycle. A frame-sync pulse makes
// the current cycle slot 0. Otherwise the count steps once per cycle and
// wraps after SLOTS-1.
// Assumes one clock cycle per time-slot.
module tsw_slot_ctr #(
    parameter int SLOTS  = 32,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    output logic [SLOT_W-1:0] slot_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] next_q;

    // current slot: forced to zero by frame sync
    always_comb slot_o = fsync_i ? '0 : next_q;

    // precompute the slot number of the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n)              next_q <= '0;
        else if (slot_o == LAST) next_q <= '0;
        else                     next_q <= slot_o + SLOT_W'(1);
    end

    assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o != LAST) |=> (fsync_i || slot_o == $past(slot_o) + SLOT_W'(1)));

    assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o == LAST) |=> (slot_o == '0));
endmodule

// File: rtl/tsw_ctrl_col.sv
// Module tsw_ctrl_col
// One column of control memory: one word per slot, each a valid bit plus an
// input-highway address. The word for the current slot is read without a
// clock, and writes land at the clock edge.
// Assumes the caller checks that wr_slot is in range.
module tsw_ctrl_col #(
    parameter int SLOTS = 32,
    parameter int SRC_W = 2,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [SRC_W-1:0]  wr_src,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_valid,
    output logic [SRC_W-1:0]  rd_src
);
    logic             valid_q [SLOTS];
    logic [SRC_W-1:0] src_q   [SLOTS];

    // store or erase one connection word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                valid_q[i] <= 1'b0;
                src_q[i]   <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_slot] <= wr_valid;
            src_q[wr_slot]   <= wr_src;
        end
    end

    // fetch the word of the slot being switched
    always_comb begin
        rd_valid = valid_q[rd_slot];
        rd_src   = src_q[rd_slot];
    end

    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid) |=> (valid_q[$past(wr_slot)] && src_q[$past(wr_slot)] == $past(wr_src)));

    assert_erase_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> !valid_q[$past(wr_slot)]);
endmodule

// File: rtl/tsw_xpoint.sv
// Module tsw_xpoint
// One output column of crosspoints. The control word enables at most one
// gate, and the gated inputs are ORed together. With no gate enabled the
// output is the idle byte.
// Assumes an input address at or above N_IN enables nothing.
module tsw_xpoint
    import tsw_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int SRC_W = 2
) (
    input  logic [N_IN*SAMPLE_W-1:0] hw_in,
    input  logic                     sel_valid,
    input  logic [SRC_W-1:0]         sel_src,
    output logic [SAMPLE_W-1:0]      hw_out
);
    logic [N_IN-1:0]     gate;
    logic [SAMPLE_W-1:0] term [N_IN];

    for (genvar k = 0; k < N_IN; k++) begin : g_gate
        // one crosspoint: closed only when addressed by a valid word
        always_comb begin
            gate[k] = sel_valid && (sel_src == SRC_W'(k));
            term[k] = hw_in[k*SAMPLE_W +: SAMPLE_W] & {SAMPLE_W{gate[k]}};
        end
    end

    // merge the gated inputs, idle byte when the column is open
    always_comb begin
        hw_out = '0;
        for (int k = 0; k < N_IN; k++) hw_out = hw_out | term[k];
        if (gate == '0) hw_out = IDLE_BYTE;
    end

    // at most one crosspoint per column in any slot
    always_comb begin
        assert_single_xpoint_R2: assert ($onehot0(gate));
    end
endmodule

// File: rtl/tsw_space_switch.sv
// Module tsw_space_switch
// Time-multiplexed space switch. There are N_IN incoming and N_OUT outgoing
// byte-wide highways, and each output has its own cyclic control memory of
// SLOTS words. The path from input to output has no register, so a sample
// leaves in the slot it arrived in.
// Assumes one cycle per slot, and that fsync_i (if used) marks slot 0.
module tsw_space_switch
    import tsw_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int SLOTS = 32,
    localparam int SRC_W  = (N_IN  > 1) ? $clog2(N_IN)  : 1,
    localparam int COL_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fsync_i,
    input  logic [N_IN*SAMPLE_W-1:0]  hw_in_i,
    input  logic                      cw_en_i,
    input  logic [COL_W-1:0]          cw_col_i,
    input  logic [SLOT_W-1:0]         cw_slot_i,
    input  logic                      cw_valid_i,
    input  logic [SRC_W-1:0]          cw_src_i,
    output logic [N_OUT*SAMPLE_W-1:0] hw_out_o
);
    logic [SLOT_W-1:0] cur_slot;
    logic              slot_ok;

    tsw_slot_ctr #(.SLOTS(SLOTS)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync_i (fsync_i),
        .slot_o  (cur_slot)
    );

    // ignore writes addressed beyond the frame
    always_comb slot_ok = (32'(cw_slot_i) < SLOTS);

    for (genvar o = 0; o < N_OUT; o++) begin : g_col
        logic             hit;
        logic             rd_valid;
        logic [SRC_W-1:0] rd_src;

        // select this column for the write
        always_comb hit = cw_en_i && slot_ok && (cw_col_i == COL_W'(o));

        tsw_ctrl_col #(.SLOTS(SLOTS), .SRC_W(SRC_W)) u_cm (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (hit),
            .wr_slot  (cw_slot_i),
            .wr_valid (cw_valid_i),
            .wr_src   (cw_src_i),
            .rd_slot  (cur_slot),
            .rd_valid (rd_valid),
            .rd_src   (rd_src)
        );

        tsw_xpoint #(.N_IN(N_IN), .SRC_W(SRC_W)) u_xp (
            .hw_in     (hw_in_i),
            .sel_valid (rd_valid),
            .sel_src   (rd_src),
            .hw_out    (hw_out_o[o*SAMPLE_W +: SAMPLE_W])
        );
    end
endmodule

// File: tb/test_tsw_space_switch.sv
module test_tsw_space_switch;
    localparam int N_IN = 4, N_OUT = 4, SLOTS = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fsync_i = 1'b0;
    logic [N_IN*8-1:0] hw_in_i = '0;
    logic              cw_en_i = 1'b0;
    logic [1:0]        cw_col_i = '0;
    logic [4:0]        cw_slot_i = '0;
    logic              cw_valid_i = 1'b0;
    logic [1:0]        cw_src_i = '0;
    logic [N_OUT*8-1:0] hw_out_o;

    int checks = 0, errors = 0;
    int cnt = 0;
    bit mv [N_OUT][SLOTS];
    int ms [N_OUT][SLOTS];

    always #10 clk = ~clk;

    tsw_space_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS)) i_tsw_space_switch (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .hw_in_i(hw_in_i),
        .cw_en_i(cw_en_i), .cw_col_i(cw_col_i), .cw_slot_i(cw_slot_i),
        .cw_valid_i(cw_valid_i), .cw_src_i(cw_src_i), .hw_out_o(hw_out_o));

    function automatic logic [7:0] expect_out(int o, int s);
        if (mv[o][s]) return hw_in_i[ms[o][s]*8 +: 8];
        return 8'hFF;
    endfunction

    // one slot: drive, check outputs against the model, then commit
    task automatic step(input bit fs, input bit we, input int col, input int sl,
                        input bit v, input int src, input string tag);
        int cur;
        @(negedge clk);
        fsync_i = fs; cw_en_i = we; cw_col_i = 2'(col); cw_slot_i = 5'(sl);
        cw_valid_i = v; cw_src_i = 2'(src);
        for (int k = 0; k < N_IN; k++) hw_in_i[k*8 +: 8] = 8'($urandom);
        #2;
        cur = fs ? 0 : cnt;
        for (int o = 0; o < N_OUT; o++) begin
            logic [7:0] e;
            string t;
            e = expect_out(o, cur);
            t = (tag != "") ? tag : (mv[o][cur] ? "R2" : "R3");
            checks++;
            if (hw_out_o[o*8 +: 8] !== e) begin
                errors++;
                $display("FAIL %s out%0d slot%0d actual %h expected %h", t, o, cur,
                         hw_out_o[o*8 +: 8], e);
            end
        end
        @(posedge clk);
        if (rst_n && we) begin mv[col][sl] = v; ms[col][sl] = src; end
        cnt = (cur == SLOTS - 1) ? 0 : cur + 1;
    endtask

    task automatic idle_run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int o = 0; o < N_OUT; o++)
            for (int s = 0; s < SLOTS; s++) begin mv[o][s] = 0; ms[o][s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        cnt = 1;
        // R1: nothing connected after reset, a full frame idles
        idle_run(SLOTS, "R1");
        // R6: write the slot being switched; old word applies this cycle
        step(0, 1, 0, cnt, 1, 2, "R6");
        idle_run(SLOTS, "R6");
        // R8: broadcast input 2 to columns 1..3 in slot 5
        step(0, 1, 1, 5, 1, 2, "R8");
        step(0, 1, 2, 5, 1, 2, "R8");
        step(0, 1, 3, 5, 1, 2, "R8");
        idle_run(SLOTS, "R8");
        // R9: one column, different inputs in neighbouring slots
        step(0, 1, 1, 8, 1, 0, "R9");
        step(0, 1, 1, 9, 1, 3, "R9");
        idle_run(SLOTS, "R9");
        // R5: frame sync in mid-frame restarts at slot 0
        while (cnt != 17) step(0, 0, 0, 0, 0, 0, "R5");
        step(1, 0, 0, 0, 0, 0, "R5");
        idle_run(SLOTS + 4, "R4");   // R4: crosses the 31 -> 0 wrap
        // R7: erase broadcast in column 2
        step(0, 1, 2, 5, 0, 0, "R7");
        idle_run(SLOTS, "R7");
        // random traffic mixed with writes and syncs
        for (int i = 0; i < 4000; i++) begin
            bit we = ($urandom % 4) == 0;
            bit fs = ($urandom % 50) == 0;
            step(fs, we, int'($urandom % N_OUT), int'($urandom % SLOTS),
                 bit'(($urandom % 4) != 0), int'($urandom % N_IN), "");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule